// File: doc/BRIEF.md
# Serial Link Receive Deframer

This block sits behind an external 8b/10b decoder on the receive side of a fixed-latency serial link. Every logic-clock cycle it takes `LANES` decoded characters. Each character is an 8-bit value with a flag that marks it as a control character. From these characters the block does three things:

- It watches where commas land and judges whether the receiver is word-aligned.
- It removes the self-synchronizing scrambling that covers both data and control traffic.
- It splits the cleaned traffic into two streams: a real-time packet stream and a low-priority auxiliary byte stream.

Cycles made only of data characters carry real-time packets. Cycles made only of control characters carry either auxiliary bits or idle/delimiter marks, encoded through a 3-bit selection value. A misaligned receiver is detected from commas that appear outside the first lane. The block then raises a reset request for the transceiver until alignment is regained. The transmitter's idle pattern produces commas regularly, so no link-training sequence is needed.

Top module: `link_rx_deframer`

## Requirements
- R1: A control character is looked up in the table of its lane. Lane 0 maps selections 0..7 to codes BC,3C,1C,5C,7C,9C,DC,FC (hex). Every other lane maps them to 1C,5C,7C,9C,DC,F7,FB,FD. A control code missing from its lane's table pulses `code_err` in the next cycle. Its descrambled selection is then taken as 3'b100, and it enters the descrambler history as symbol 00.
- R2: Characters are processed in order, lane 0 first and then across cycles. A data character's symbol is its byte. A valid control character's symbol is {5'b0, table index}. Let h1 be the previous symbol and h2 the one before it; both start at 00 after reset. The key is h1 ^ h2 ^ {h2[3:0],h2[7:4]}. The plain value is symbol ^ key, and only the low 3 bits are used for control lanes. After two characters the output no longer depends on the initial state.
- R3: A comma is a control code of 3C, BC or FC. A cycle with a comma in lane 0 and none elsewhere counts as one sighting. After `ALIGN_COUNT` sightings with no stray comma in between, `link_aligned` rises in the cycle after the last sighting.
- R4: A comma in any lane other than 0 has three effects: it clears `link_aligned`, it clears the sighting count, and it sets `rx_reset_req` from the next cycle on. `rx_reset_req` stays high until `link_aligned` rises again.
- R5: Consecutive all-data cycles form one real-time packet. Each such cycle appears on `rt_data` two cycles after it is received, with lane 0 in bits [7:0]. `rt_sop` marks the first beat of a packet.
- R6: `rt_eop` marks the last beat of a packet. It is set when the cycle after that beat is not an all-data cycle.
- R7: A cycle that mixes data and control characters pulses `framing_err` in the next cycle. The pending beat of a packet in progress is emitted in that same cycle with `rt_eop` and `rt_abort` set. The mixed cycle contributes neither a beat nor auxiliary bits.
- R8: In all-control cycles, a selection 3'b0ab adds the bit pair ab to the auxiliary byte, and the first pair lands in bits [7:6]. A completed byte is held back. It is output on `aux_valid` one cycle after the next selection that carries a pair or a delimiter, with `aux_last` low in the first case and high in the second.
- R9: A selection with bit 2 set is a delimiter or idle. It ends the auxiliary packet and discards any incomplete byte. All-data cycles leave the auxiliary state untouched.
- R10: While `rst` is high and in the first cycle after it, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | logic clock |
| rst | input | 1 | synchronous active-high reset |
| rx_char | input | LANES*8 | decoded characters, lane 0 in [7:0] |
| rx_is_k | input | LANES | per-lane control-character flag |
| rt_valid | output | 1 | real-time beat valid |
| rt_data | output | LANES*8 | descrambled real-time beat |
| rt_sop | output | 1 | first beat of a packet |
| rt_eop | output | 1 | last beat of a packet |
| rt_abort | output | 1 | packet ended by a framing error |
| aux_valid | output | 1 | auxiliary byte valid |
| aux_byte | output | 8 | auxiliary byte |
| aux_last | output | 1 | last byte of an auxiliary packet |
| link_aligned | output | 1 | commas are steadily in lane 0 |
| rx_reset_req | output | 1 | request to reset the transceiver receiver |
| framing_err | output | 1 | mixed data/control cycle seen |
| code_err | output | 1 | control code not valid for its lane |

## Verification
The bench builds the block with `LANES=2` and `ALIGN_COUNT=16`, so both control tables and the stray-comma path in lane 1 are in use. With these values, idle traffic puts a comma in lane 0 on two of every three cycles, so the 16-sighting window closes within about 24 cycles and realignment can be repeated several times in one run. Two lanes deliver four auxiliary bits per control cycle, so completed bytes wait across cycle boundaries and across interleaved data cycles before a pair or a delimiter releases them.

// File: rtl/lrx_pkg.sv
`timescale 1ns/1ps
package lrx_pkg;
  localparam logic [2:0] SEL_IDLE = 3'b100;

  // Control code for a selection; head = first lane (table with commas)
  function automatic logic [7:0] ctrl_code(input logic head, input logic [2:0] sel);
    logic [7:0] c;
    if (head) begin
      case (sel)
        3'd0: c = 8'hBC;
        3'd1: c = 8'h3C;
        3'd2: c = 8'h1C;
        3'd3: c = 8'h5C;
        3'd4: c = 8'h7C;
        3'd5: c = 8'h9C;
        3'd6: c = 8'hDC;
        default: c = 8'hFC;
      endcase
    end else begin
      case (sel)
        3'd0: c = 8'h1C;
        3'd1: c = 8'h5C;
        3'd2: c = 8'h7C;
        3'd3: c = 8'h9C;
        3'd4: c = 8'hDC;
        3'd5: c = 8'hF7;
        3'd6: c = 8'hFB;
        default: c = 8'hFD;
      endcase
    end
    return c;
  endfunction

  function automatic logic is_comma(input logic [7:0] c);
    return (c == 8'h3C) || (c == 8'hBC) || (c == 8'hFC);
  endfunction

  function automatic logic [7:0] keystream(input logic [7:0] h1, input logic [7:0] h2);
    return h1 ^ h2 ^ {h2[3:0], h2[7:4]};
  endfunction
endpackage

// File: rtl/lrx_lane_decode.sv
`timescale 1ns/1ps
module lrx_lane_decode import lrx_pkg::*; #(
  parameter int HEAD = 0
) (
  input  logic [7:0] char_in,
  input  logic       is_k,
  output logic [7:0] sym,
  output logic       comma,
  output logic       bad
);
  always_comb begin
    sym   = char_in;
    bad   = 1'b0;
    comma = is_k && is_comma(char_in);
    if (is_k) begin
      bad = 1'b1;
      sym = 8'h00;
      for (int s = 0; s < 8; s++) begin
        if (ctrl_code(HEAD != 0, 3'(s)) == char_in) begin
          bad = 1'b0;
          sym = {5'b0, 3'(s)};
        end
      end
    end
  end
endmodule

// File: rtl/lrx_descrambler.sv
`timescale 1ns/1ps
module lrx_descrambler import lrx_pkg::*; #(
  parameter int LANES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [LANES-1:0][7:0] sym_in,
  output logic [LANES-1:0][7:0] plain_out
);
  logic [7:0] h1_q, h2_q, h1_n, h2_n;

  always_comb begin
    h1_n = h1_q;
    h2_n = h2_q;
    for (int i = 0; i < LANES; i++) begin
      plain_out[i] = sym_in[i] ^ keystream(h1_n, h2_n);
      h2_n = h1_n;
      h1_n = sym_in[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      h1_q <= 8'h00;
      h2_q <= 8'h00;
    end else begin
      h1_q <= h1_n;
      h2_q <= h2_n;
    end
  end
endmodule

// File: rtl/lrx_align_mon.sv
`timescale 1ns/1ps
module lrx_align_mon #(
  parameter int LANES       = 2,
  parameter int ALIGN_COUNT = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] comma,
  output logic             aligned,
  output logic             reset_req
);
  localparam int CW = $clog2(ALIGN_COUNT + 1);
  logic [CW-1:0] cnt_q;
  logic          stray;

  generate
    if (LANES > 1) begin : g_multi
      assign stray = |comma[LANES-1:1];
    end else begin : g_single
      assign stray = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      aligned   <= 1'b0;
      reset_req <= 1'b0;
    end else if (stray) begin
      cnt_q     <= '0;
      aligned   <= 1'b0;
      reset_req <= 1'b1;
    end else if (comma[0] && !aligned) begin
      if (cnt_q == CW'(ALIGN_COUNT - 1)) begin
        cnt_q     <= '0;
        aligned   <= 1'b1;
        reset_req <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lrx_aux_asm.sv
`timescale 1ns/1ps
module lrx_aux_asm #(
  parameter int LANES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en,
  input  logic [LANES-1:0][2:0] sel,
  output logic                  aux_valid,
  output logic [7:0]            aux_byte,
  output logic                  aux_last
);
  logic [7:0] acc_q, acc_n, pb_q, pb_n, ob;
  logic [1:0] cnt_q, cnt_n;
  logic       pend_q, pend_n, ov, ol;

  always_comb begin
    acc_n  = acc_q;
    cnt_n  = cnt_q;
    pend_n = pend_q;
    pb_n   = pb_q;
    ov = 1'b0;
    ob = pb_q;
    ol = 1'b0;
    if (en) begin
      for (int i = 0; i < LANES; i++) begin
        if (!sel[i][2]) begin
          if (pend_n) begin
            ov = 1'b1; ob = pb_n; ol = 1'b0; pend_n = 1'b0;
          end
          acc_n = {acc_n[5:0], sel[i][1:0]};
          if (cnt_n == 2'd3) begin
            pend_n = 1'b1;
            pb_n   = acc_n;
          end
          cnt_n = cnt_n + 2'd1;
        end else begin
          if (pend_n) begin
            ov = 1'b1; ob = pb_n; ol = 1'b1; pend_n = 1'b0;
          end
          cnt_n = 2'd0;
          acc_n = 8'h00;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= 8'h00; cnt_q <= 2'd0; pend_q <= 1'b0; pb_q <= 8'h00;
      aux_valid <= 1'b0; aux_byte <= 8'h00; aux_last <= 1'b0;
    end else begin
      acc_q <= acc_n; cnt_q <= cnt_n; pend_q <= pend_n; pb_q <= pb_n;
      aux_valid <= ov; aux_byte <= ob; aux_last <= ol;
    end
  end
endmodule

// File: rtl/link_rx_deframer.sv
`timescale 1ns/1ps
module link_rx_deframer import lrx_pkg::*; #(
  parameter int LANES       = 2,
  parameter int ALIGN_COUNT = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [LANES*8-1:0] rx_char,
  input  logic [LANES-1:0]   rx_is_k,
  output logic               rt_valid,
  output logic [LANES*8-1:0] rt_data,
  output logic               rt_sop,
  output logic               rt_eop,
  output logic               rt_abort,
  output logic               aux_valid,
  output logic [7:0]         aux_byte,
  output logic               aux_last,
  output logic               link_aligned,
  output logic               rx_reset_req,
  output logic               framing_err,
  output logic               code_err
);
  localparam int DW = LANES * 8;

  logic [LANES-1:0][7:0] rx_lane, sym, plain;
  logic [LANES-1:0][2:0] sel_eff;
  logic [LANES-1:0]      comma, bad;
  logic                  all_k, all_d, mixed;
  logic                  stg_v, stg_first;
  logic [DW-1:0]         stg_data;

  assign rx_lane = rx_char;
  assign all_k   = &rx_is_k;
  assign all_d   = ~|rx_is_k;
  assign mixed   = !all_k && !all_d;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      lrx_lane_decode #(.HEAD(g == 0 ? 1 : 0)) u_dec (
        .char_in (rx_lane[g]),
        .is_k    (rx_is_k[g]),
        .sym     (sym[g]),
        .comma   (comma[g]),
        .bad     (bad[g])
      );
      assign sel_eff[g] = bad[g] ? SEL_IDLE : plain[g][2:0];
    end
  endgenerate

  lrx_descrambler #(.LANES(LANES)) u_scr (
    .clk(clk), .rst(rst), .sym_in(sym), .plain_out(plain)
  );

  lrx_align_mon #(.LANES(LANES), .ALIGN_COUNT(ALIGN_COUNT)) u_align (
    .clk(clk), .rst(rst), .comma(comma),
    .aligned(link_aligned), .reset_req(rx_reset_req)
  );

  lrx_aux_asm #(.LANES(LANES)) u_aux (
    .clk(clk), .rst(rst), .en(all_k), .sel(sel_eff),
    .aux_valid(aux_valid), .aux_byte(aux_byte), .aux_last(aux_last)
  );

  // One-beat staging so the end of a packet is known when the beat leaves
  always_ff @(posedge clk) begin
    if (rst) begin
      stg_v <= 1'b0; stg_first <= 1'b0; stg_data <= '0;
      rt_valid <= 1'b0; rt_data <= '0; rt_sop <= 1'b0;
      rt_eop <= 1'b0; rt_abort <= 1'b0;
      framing_err <= 1'b0; code_err <= 1'b0;
    end else begin
      rt_valid    <= stg_v;
      rt_data     <= stg_data;
      rt_sop      <= stg_v && stg_first;
      rt_eop      <= stg_v && !all_d;
      rt_abort    <= stg_v && mixed;
      stg_first   <= !stg_v;
      stg_v       <= all_d;
      stg_data    <= plain;
      framing_err <= mixed;
      code_err    <= |(bad & rx_is_k);
    end
  end
endmodule

// File: rtl/lrx_checker.sv
`timescale 1ns/1ps
module lrx_checker (
  input logic clk,
  input logic rst,
  input logic rt_valid,
  input logic rt_sop,
  input logic rt_eop,
  input logic rt_abort,
  input logic aux_valid,
  input logic aux_last,
  input logic link_aligned,
  input logic rx_reset_req,
  input logic framing_err
);
  p_cont_r5: assert property (@(posedge clk) disable iff (rst)
    rt_valid && !rt_eop |=> rt_valid && !rt_sop);
  p_start_r5: assert property (@(posedge clk) disable iff (rst)
    rt_valid && !$past(rt_valid) |-> rt_sop);
  p_gap_r6: assert property (@(posedge clk) disable iff (rst)
    rt_valid && rt_eop |=> !rt_valid);
  p_abort_r7: assert property (@(posedge clk) disable iff (rst)
    rt_abort |-> rt_valid && rt_eop && framing_err);
  p_last_r8: assert property (@(posedge clk) disable iff (rst)
    aux_last |-> aux_valid);
  p_req_r4: assert property (@(posedge clk) disable iff (rst)
    rx_reset_req |-> !link_aligned);
  p_rise_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(link_aligned) |-> !rx_reset_req);
endmodule

bind link_rx_deframer lrx_checker u_chk (
  .clk(clk), .rst(rst), .rt_valid(rt_valid), .rt_sop(rt_sop),
  .rt_eop(rt_eop), .rt_abort(rt_abort), .aux_valid(aux_valid),
  .aux_last(aux_last), .link_aligned(link_aligned),
  .rx_reset_req(rx_reset_req), .framing_err(framing_err)
);

// File: tb/sim_link_rx_deframer.sv
`timescale 1ns/1ps
module sim_link_rx_deframer;
  localparam int LANES = 2;
  localparam int ALIGN = 16;
  localparam int DW    = LANES * 8;

  logic clk = 1'b0, rst = 1'b1;
  logic [DW-1:0]    rx_char = '0;
  logic [LANES-1:0] rx_is_k = '0;
  logic rt_valid, rt_sop, rt_eop, rt_abort, aux_valid, aux_last;
  logic link_aligned, rx_reset_req, framing_err, code_err;
  logic [DW-1:0] rt_data;
  logic [7:0] aux_byte;

  always #2.5 clk = ~clk;

  link_rx_deframer #(.LANES(LANES), .ALIGN_COUNT(ALIGN)) u0 (
    .clk(clk), .rst(rst), .rx_char(rx_char), .rx_is_k(rx_is_k),
    .rt_valid(rt_valid), .rt_data(rt_data), .rt_sop(rt_sop), .rt_eop(rt_eop),
    .rt_abort(rt_abort), .aux_valid(aux_valid), .aux_byte(aux_byte),
    .aux_last(aux_last), .link_aligned(link_aligned), .rx_reset_req(rx_reset_req),
    .framing_err(framing_err), .code_err(code_err)
  );

  int checks = 0, fails = 0, cyc = 0;

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // R1 tables
  function automatic logic [7:0] tab(input bit head, input logic [2:0] s);
    logic [7:0] h [8] = '{8'hBC, 8'h3C, 8'h1C, 8'h5C, 8'h7C, 8'h9C, 8'hDC, 8'hFC};
    logic [7:0] o [8] = '{8'h1C, 8'h5C, 8'h7C, 8'h9C, 8'hDC, 8'hF7, 8'hFB, 8'hFD};
    return head ? h[s] : o[s];
  endfunction

  // {bad, symbol} per R1/R2
  function automatic logic [8:0] lane_sym(input int lane, input logic [7:0] ch, input logic k);
    if (!k) return {1'b0, ch};
    for (int s = 0; s < 8; s++)
      if (tab(lane == 0, 3'(s)) == ch) return {4'b0, 5'b0, 3'(s)} ;
    return 9'h100;
  endfunction

  function automatic logic [7:0] ks(input logic [7:0] a, input logic [7:0] b);
    return a ^ b ^ {b[3:0], b[7:4]};
  endfunction

  // ---------------- transmitter ----------------
  logic [7:0] t_h1 = 8'h00, t_h2 = 8'h00;
  logic [DW-1:0] rt_q[$];

  task automatic drive(input logic [DW-1:0] ch, input logic [LANES-1:0] k);
    logic [8:0] r;
    @(negedge clk);
    rx_char = ch;
    rx_is_k = k;
    for (int l = 0; l < LANES; l++) begin
      r = lane_sym(l, ch[l*8 +: 8], k[l]);
      t_h2 = t_h1;
      t_h1 = r[7:0];
    end
  endtask

  // K lanes: low 3 bits of the lane byte are the selection
  task automatic send(input logic [LANES-1:0] k, input logic [DW-1:0] pl);
    logic [DW-1:0] ch;
    logic [7:0] a, b, key, s;
    logic [2:0] sc;
    a = t_h1; b = t_h2;
    for (int l = 0; l < LANES; l++) begin
      key = ks(a, b);
      if (k[l]) begin
        sc = pl[l*8 +: 3] ^ key[2:0];
        ch[l*8 +: 8] = tab(l == 0, sc);
        s = {5'b0, sc};
      end else begin
        s = pl[l*8 +: 8] ^ key;
        ch[l*8 +: 8] = s;
      end
      b = a; a = s;
    end
    if (k == '0) rt_q.push_back(pl);
    drive(ch, k);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) send('1, {8'h04, 8'h04});
  endtask

  // ---------------- reference model ----------------
  logic [7:0] m_h1, m_h2, m_acc, m_pb, e_ab;
  int m_cnt, m_pairs;
  bit m_al, m_req, m_pend, s_v, s_first;
  bit e_rtv, e_sop, e_eop, e_abt, e_av, e_al, e_fe, e_ce;
  logic [DW-1:0] s_d, e_rtd;

  always @(posedge clk) begin : model
    bit allk, alld, mix;
    bit [LANES-1:0] cm, bd;
    logic [2:0] sl [LANES];
    logic [DW-1:0] pl;
    logic [8:0] r;
    if (rst) begin
      m_h1 = 0; m_h2 = 0; m_acc = 0; m_pb = 0; e_ab = 0;
      m_cnt = 0; m_pairs = 0; m_al = 0; m_req = 0; m_pend = 0;
      s_v = 0; s_first = 0; s_d = 0;
      e_rtv = 0; e_sop = 0; e_eop = 0; e_abt = 0; e_av = 0; e_al = 0;
      e_fe = 0; e_ce = 0; e_rtd = 0;
    end else begin
      allk = (rx_is_k == '1);
      alld = (rx_is_k == '0);
      mix  = !allk && !alld;
      for (int l = 0; l < LANES; l++) begin
        r = lane_sym(l, rx_char[l*8 +: 8], rx_is_k[l]);
        bd[l] = r[8];
        pl[l*8 +: 8] = r[7:0] ^ ks(m_h1, m_h2);
        sl[l] = r[8] ? 3'b100 : pl[l*8 +: 3];
        m_h2 = m_h1; m_h1 = r[7:0];
        cm[l] = rx_is_k[l] && (rx_char[l*8 +: 8] inside {8'h3C, 8'hBC, 8'hFC});
      end
      e_rtv = s_v; e_rtd = s_d; e_sop = s_v && s_first;
      e_eop = s_v && !alld; e_abt = s_v && mix;
      s_first = !s_v; s_v = alld; s_d = pl;
      e_fe = mix; e_ce = |(bd & rx_is_k);
      if (|cm[LANES-1:1]) begin
        m_al = 0; m_cnt = 0; m_req = 1;
      end else if (cm[0] && !m_al) begin
        m_cnt++;
        if (m_cnt == ALIGN) begin m_al = 1; m_req = 0; m_cnt = 0; end
      end
      e_av = 0; e_al = 0;
      if (allk) begin
        for (int l = 0; l < LANES; l++) begin
          if (!sl[l][2]) begin
            if (m_pend) begin e_av = 1; e_ab = m_pb; e_al = 0; m_pend = 0; end
            m_acc = {m_acc[5:0], sl[l][1:0]};
            m_pairs++;
            if (m_pairs == 4) begin m_pend = 1; m_pb = m_acc; m_pairs = 0; end
          end else begin
            if (m_pend) begin e_av = 1; e_ab = m_pb; e_al = 1; m_pend = 0; end
            m_pairs = 0; m_acc = 0;
          end
        end
      end
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (!rst) begin
      check("R5", "rt_valid", rt_valid, e_rtv);
      check("R5", "rt_sop", rt_sop, e_sop);
      check("R6", "rt_eop", rt_eop, e_eop);
      check("R7", "rt_abort", rt_abort, e_abt);
      check("R7", "framing_err", framing_err, e_fe);
      check("R1", "code_err", code_err, e_ce);
      check("R3", "link_aligned", link_aligned, m_al);
      check("R4", "rx_reset_req", rx_reset_req, m_req);
      check("R8", "aux_valid", aux_valid, e_av);
      if (e_av) begin
        check("R8", "aux_byte", aux_byte, e_ab);
        check("R9", "aux_last", aux_last, e_al);
      end
      if (e_rtv) check("R2", "rt_data model", rt_data, e_rtd);
      if (rt_valid) begin
        if (rt_q.size() == 0) check("R5", "unexpected beat", 1, 0);
        else check("R2", "rt_data plaintext", rt_data, rt_q.pop_front());
      end
    end
  end

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      fails++;
      $display("FAIL watchdog all-R cycles actual=%0d expected<50000", cyc);
      summary();
      $finish;
    end
  end

  task automatic after_edge;
    @(posedge clk); #1;
  endtask

  initial begin
    rx_is_k = '1;
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    check("R10", "outputs in reset",
          {rt_valid, rt_sop, rt_eop, rt_abort, aux_valid, aux_last,
           link_aligned, rx_reset_req, framing_err, code_err}, 0);
    check("R10", "rt_data in reset", rt_data, 0);
    @(negedge clk); rst = 1'b0;
    #1;
    check("R10", "first cycle after reset", {rt_valid, aux_valid, link_aligned}, 0);

    // R3 alignment build-up on idle traffic
    idle(5);
    after_edge();
    check("R3", "not aligned early", link_aligned, 0);
    idle(25);
    after_edge();
    check("R3", "aligned after idle", link_aligned, 1);

    // R5/R6 packets: three beats, single beat, back-to-back
    send('0, 16'h1234); send('0, 16'hABCD); send('0, 16'h0F0F); idle(1);
    send('0, 16'h5AA5); idle(1);
    send('0, 16'h0001); send('0, 16'hFFFF); idle(3);

    // R8/R9 auxiliary byte A5 then delimiter
    send('1, {8'h02, 8'h02}); send('1, {8'h01, 8'h01});
    send('1, {8'h04, 8'h04});
    after_edge();
    check("R8", "aux byte A5", {aux_valid, aux_byte}, {1'b1, 8'hA5});
    check("R9", "aux last on delimiter", aux_last, 1);
    // two bytes with a data cycle in between, then partial byte discarded
    send('1, {8'h03, 8'h00}); send('0, 16'h7777); send('1, {8'h01, 8'h02});
    send('1, {8'h00, 8'h03}); send('1, {8'h03, 8'h03});
    send('1, {8'h04, 8'h01}); idle(4);

    // R7 mixed cycle during a packet and outside one
    send('0, 16'h2222); send('0, 16'h3333); send(2'b10, {8'h01, 8'h44}); idle(2);
    send(2'b01, {8'h99, 8'h00}); idle(2);

    // R4 comma in lane 1, then R1 bad code in lane 0
    drive({8'hBC, 8'h7C}, 2'b11);
    after_edge();
    check("R4", "reset request", {rx_reset_req, link_aligned}, 2'b10);
    check("R1", "stray comma is bad code", code_err, 1);
    idle(30);
    after_edge();
    check("R4", "realigned, request dropped", {rx_reset_req, link_aligned}, 2'b01);
    drive({8'h1C, 8'h00}, 2'b11);
    after_edge();
    check("R1", "bad lane-0 code", code_err, 1);
    idle(4);

    // mixed random traffic
    for (int i = 0; i < 600; i++) begin
      int r;
      r = $urandom_range(0, 7);
      if (r < 4)      send('0, DW'($urandom));
      else if (r < 6) send('1, DW'($urandom));
      else if (r == 6) send(($urandom_range(0, 1) != 0) ? 2'b01 : 2'b10, DW'($urandom));
      else            idle(1);
    end
    idle(40);
    after_edge();
    check("R5", "all beats delivered", rt_q.size(), 0);
    summary();
    $finish;
  end
endmodule